// File: doc/BRIEF.md
# Parity-Banked Floating Register File

This block is the architectural register storage for a floating-point datapath. It holds 128 registers of 82 bits each and serves eight combinational read ports. Two write ports carry results from the arithmetic units, one value per port per cycle. Two more write ports carry data returning from memory, and each of these delivers a pair of values per cycle.

Storage is split by the lowest bit of the register number: even registers sit in one bank and odd registers in the other. A paired memory return is accepted only when one destination is even and the other is odd, so each bank takes one value from each memory port. The two memory ports therefore commit four values per clock without any extra physical write ports on either bank. A pair whose two destinations share a parity is dropped and flagged.

Concurrent writes to the same register resolve by a fixed priority. A read of a register that is being written in the same cycle returns the winning new value. Register 0 is hardwired to zero.

Top module: `fp_banked_rf`

## Requirements
- R1: After synchronous reset every register reads as zero on every read port.
- R2: A value written through an arithmetic result port (`ex_we[i]` high) is returned by any read port from the cycle after the clock edge onward.
- R3: A memory pair (`ld_we[i]` high) whose destinations `ld_addr_a[i]` and `ld_addr_b[i]` differ in bit 0 writes both values at one clock edge. With both memory ports active, four registers are written per cycle.
- R4: A memory pair whose two destinations have the same bit 0 writes neither destination.
- R5: `ld_pair_err[i]` is high for exactly the one cycle following an edge at which port i presented a same-parity pair, and low otherwise.
- R6: When several writes target one register in a cycle, the priority is ex port 0, then ex port 1, then memory port 0, then memory port 1. Only the highest-priority value is stored.
- R7: A read of a register that is being written in the same cycle returns the value that R6 selects, before the clock edge.
- R8: Register 0 always reads as zero, and writes to it from any port are discarded.
- R9: The eight read ports each return their own addressed register independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 8x7 | Read address per read port |
| rd_data | output | 8x82 | Read data per read port (combinational, bypassed) |
| ex_we | input | 2 | Arithmetic result write enables |
| ex_addr | input | 2x7 | Arithmetic result destinations |
| ex_data | input | 2x82 | Arithmetic result values |
| ld_we | input | 2 | Memory pair write enables |
| ld_addr_a | input | 2x7 | First destination of each memory pair |
| ld_data_a | input | 2x82 | First value of each memory pair |
| ld_addr_b | input | 2x7 | Second destination of each memory pair |
| ld_data_b | input | 2x82 | Second value of each memory pair |
| ld_pair_err | output | 2 | One-cycle flag for a rejected same-parity pair |

## Verification
If a bank row or the arbitration held the wrong state, the wrong value would appear on a read port in the first quiet cycle after the edge that committed it. The full sweeps read back every register through all eight ports, so a fault in any row is exposed within one sweep. A bypass or priority error shows in the same cycle as the colliding write, before any edge, while a missed pair rejection shows both as a corrupted register and as a missing error pulse one cycle after the request.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_REGS       = 128;
    localparam int RF_WIDTH      = 82;
    localparam int RF_RD_PORTS   = 8;
    localparam int RF_EX_PORTS   = 2;
    localparam int RF_LD_PORTS   = 2;
    localparam int RF_BANKS      = 2;
    localparam int RF_AW         = $clog2(RF_REGS);
    localparam int RF_ROW_W      = RF_AW - 1;
    localparam int RF_BANK_DEPTH = RF_REGS / RF_BANKS;
    localparam int RF_WREQS      = RF_EX_PORTS + 2 * RF_LD_PORTS;

    typedef logic [RF_AW-1:0]    reg_addr_t;
    typedef logic [RF_WIDTH-1:0] reg_word_t;
    typedef logic [RF_ROW_W-1:0] row_idx_t;

    // One write request; array position encodes priority (0 = highest).
    typedef struct packed {
        logic      valid;
        reg_addr_t addr;
        reg_word_t data;
    } wreq_t;

    function automatic logic bank_of(reg_addr_t a);
        return a[0];
    endfunction

    function automatic row_idx_t row_of(reg_addr_t a);
        return a[RF_AW-1:1];
    endfunction

    function automatic logic parity_clash(reg_addr_t a, reg_addr_t b);
        return a[0] == b[0];
    endfunction
endpackage

// File: rtl/rf_pair_check.sv
module rf_pair_check
    import rf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  reg_addr_t addr_a,
    input  reg_addr_t addr_b,
    output logic      accept,
    output logic      err
);
    logic clash;

    assign clash  = valid && parity_clash(addr_a, addr_b);
    assign accept = valid && !clash;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= clash;
    end

    p_err_after_bad_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && addr_a[0] == addr_b[0]) |=> err);
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !(valid && addr_a[0] == addr_b[0]) |=> !err);
endmodule

// File: rtl/rf_write_arbiter.sv
module rf_write_arbiter
    import rf_pkg::*;
(
    input  wreq_t req_in  [RF_WREQS],
    output wreq_t req_out [RF_WREQS]
);
    // Keep a request only if it is live, not aimed at register 0,
    // and no higher-priority request targets the same register.
    always_comb begin
        for (int j = 0; j < RF_WREQS; j++) begin
            req_out[j]       = req_in[j];
            req_out[j].valid = req_in[j].valid && (req_in[j].addr != '0);
            for (int k = 0; k < j; k++) begin
                if (req_in[k].valid && req_in[k].addr == req_in[j].addr)
                    req_out[j].valid = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  wreq_t     req     [RF_WREQS],
    input  row_idx_t  rd_row  [RF_RD_PORTS],
    output reg_word_t rd_word [RF_RD_PORTS]
);
    reg_word_t mem [RF_BANK_DEPTH];
    logic [RF_WREQS-1:0] hit;

    always_comb begin
        for (int j = 0; j < RF_WREQS; j++)
            hit[j] = req[j].valid && (bank_of(req[j].addr) == 1'(BANK_ID));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < RF_BANK_DEPTH; r++) mem[r] <= '0;
        end else begin
            for (int j = 0; j < RF_WREQS; j++)
                if (hit[j]) mem[row_of(req[j].addr)] <= req[j].data;
        end
    end

    generate
        for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
            assign rd_word[p] = mem[rd_row[p]];
        end
    endgenerate

    p_commit_r2: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> mem[$past(row_of(req[0].addr))] == $past(req[0].data));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  reg_addr_t addr,
    input  wreq_t     req [RF_WREQS],
    input  reg_word_t even_word,
    input  reg_word_t odd_word,
    output reg_word_t data
);
    always_comb begin
        data = bank_of(addr) ? odd_word : even_word;
        for (int j = RF_WREQS - 1; j >= 0; j--) begin
            if (req[j].valid && req[j].addr == addr) data = req[j].data;
        end
        if (addr == '0) data = '0;
    end
endmodule

// File: rtl/fp_banked_rf.sv
module fp_banked_rf
    import rf_pkg::*;
(
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [RF_RD_PORTS-1:0][RF_AW-1:0]        rd_addr,
    output logic [RF_RD_PORTS-1:0][RF_WIDTH-1:0]     rd_data,
    input  logic [RF_EX_PORTS-1:0]                   ex_we,
    input  logic [RF_EX_PORTS-1:0][RF_AW-1:0]        ex_addr,
    input  logic [RF_EX_PORTS-1:0][RF_WIDTH-1:0]     ex_data,
    input  logic [RF_LD_PORTS-1:0]                   ld_we,
    input  logic [RF_LD_PORTS-1:0][RF_AW-1:0]        ld_addr_a,
    input  logic [RF_LD_PORTS-1:0][RF_WIDTH-1:0]     ld_data_a,
    input  logic [RF_LD_PORTS-1:0][RF_AW-1:0]        ld_addr_b,
    input  logic [RF_LD_PORTS-1:0][RF_WIDTH-1:0]     ld_data_b,
    output logic [RF_LD_PORTS-1:0]                   ld_pair_err
);
    wreq_t     req_raw   [RF_WREQS];
    wreq_t     req_win   [RF_WREQS];
    logic [RF_LD_PORTS-1:0] ld_accept;
    row_idx_t  rd_row    [RF_RD_PORTS];
    reg_word_t bank_word [RF_BANKS][RF_RD_PORTS];

    generate
        for (genvar e = 0; e < RF_EX_PORTS; e++) begin : g_ex
            assign req_raw[e] = '{valid: ex_we[e], addr: ex_addr[e], data: ex_data[e]};
        end

        for (genvar l = 0; l < RF_LD_PORTS; l++) begin : g_ld
            rf_pair_check u_chk (
                .clk    (clk),
                .rst    (rst),
                .valid  (ld_we[l]),
                .addr_a (ld_addr_a[l]),
                .addr_b (ld_addr_b[l]),
                .accept (ld_accept[l]),
                .err    (ld_pair_err[l])
            );
            assign req_raw[RF_EX_PORTS + 2*l] =
                '{valid: ld_accept[l], addr: ld_addr_a[l], data: ld_data_a[l]};
            assign req_raw[RF_EX_PORTS + 2*l + 1] =
                '{valid: ld_accept[l], addr: ld_addr_b[l], data: ld_data_b[l]};
        end
    endgenerate

    rf_write_arbiter u_arb (
        .req_in  (req_raw),
        .req_out (req_win)
    );

    generate
        for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_row
            assign rd_row[p] = row_of(rd_addr[p]);
        end

        for (genvar b = 0; b < RF_BANKS; b++) begin : g_bank
            rf_bank #(.BANK_ID(b)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .req     (req_win),
                .rd_row  (rd_row),
                .rd_word (bank_word[b])
            );
        end

        for (genvar p = 0; p < RF_RD_PORTS; p++) begin : g_rd
            rf_read_port u_rd (
                .addr      (rd_addr[p]),
                .req       (req_win),
                .even_word (bank_word[0][p]),
                .odd_word  (bank_word[1][p]),
                .data      (rd_data[p])
            );
        end
    endgenerate

    p_bypass_ex0_r7: assert property (@(posedge clk) disable iff (rst)
        (ex_we[0] && ex_addr[0] != '0 && rd_addr[0] == ex_addr[0])
            |-> rd_data[0] == ex_data[0]);
    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[0] == '0) |-> rd_data[0] == '0);
endmodule

// File: tb/fp_banked_rf_tb_top.sv
module fp_banked_rf_tb_top;
    import rf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [RF_RD_PORTS-1:0][RF_AW-1:0]    rd_addr;
    logic [RF_RD_PORTS-1:0][RF_WIDTH-1:0] rd_data;
    logic [RF_EX_PORTS-1:0]               ex_we;
    logic [RF_EX_PORTS-1:0][RF_AW-1:0]    ex_addr;
    logic [RF_EX_PORTS-1:0][RF_WIDTH-1:0] ex_data;
    logic [RF_LD_PORTS-1:0]               ld_we;
    logic [RF_LD_PORTS-1:0][RF_AW-1:0]    ld_addr_a, ld_addr_b;
    logic [RF_LD_PORTS-1:0][RF_WIDTH-1:0] ld_data_a, ld_data_b;
    logic [RF_LD_PORTS-1:0]               ld_pair_err;

    int checks = 0;
    int failures = 0;
    reg_word_t model [RF_REGS];

    always #4 clk = ~clk;

    fp_banked_rf dut_i (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .ex_we(ex_we), .ex_addr(ex_addr), .ex_data(ex_data),
        .ld_we(ld_we), .ld_addr_a(ld_addr_a), .ld_data_a(ld_data_a),
        .ld_addr_b(ld_addr_b), .ld_data_b(ld_data_b), .ld_pair_err(ld_pair_err)
    );

    function automatic reg_word_t pat(int a, int s);
        logic [95:0] t;
        t = {32'(a * 40503 + s), 32'((s * 7919) ^ a), 32'(~(a + s * 3))};
        return t[RF_WIDTH-1:0];
    endfunction

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ex_we = '0; ex_addr = '0; ex_data = '0;
        ld_we = '0; ld_addr_a = '0; ld_addr_b = '0;
        ld_data_a = '0; ld_data_b = '0;
    endtask

    task automatic quiet_cycle();
        @(negedge clk); idle(); #1;
    endtask

    task automatic read_all(string tag);
        for (int g = 0; g < RF_REGS / RF_RD_PORTS; g++) begin
            for (int p = 0; p < RF_RD_PORTS; p++) rd_addr[p] = RF_AW'(g * RF_RD_PORTS + p);
            #1;
            for (int p = 0; p < RF_RD_PORTS; p++)
                chk(tag, rd_data[p], model[g * RF_RD_PORTS + p]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        rd_addr = '0;
        for (int r = 0; r < RF_REGS; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;

        // R1: reset state through all ports
        read_all("R1 reset zero");
        chk("R5 no error after reset", ld_pair_err, 0);

        // R3: two memory pairs per cycle, four registers per cycle, both orders
        for (int m = 0; m < RF_REGS / 4; m++) begin
            @(negedge clk);
            ld_we = '1;
            ld_addr_a[0] = RF_AW'(4*m + 1); ld_data_a[0] = pat(4*m + 1, 1);
            ld_addr_b[0] = RF_AW'(4*m);     ld_data_b[0] = pat(4*m, 1);
            ld_addr_a[1] = RF_AW'(4*m + 2); ld_data_a[1] = pat(4*m + 2, 1);
            ld_addr_b[1] = RF_AW'(4*m + 3); ld_data_b[1] = pat(4*m + 3, 1);
            @(posedge clk);
            for (int k = 0; k < 4; k++) if (4*m + k != 0) model[4*m + k] = pat(4*m + k, 1);
        end
        quiet_cycle();
        read_all("R3 paired load sweep / R8 reg0 / R9 ports");
        chk("R5 good pairs raise no error", ld_pair_err, 0);

        // R2: arithmetic ports overwrite every register
        for (int m = 0; m < RF_REGS / 2; m++) begin
            @(negedge clk);
            ex_we = '1;
            ex_addr[0] = RF_AW'(2*m + 1); ex_data[0] = pat(2*m + 1, 2);
            ex_addr[1] = RF_AW'(2*m);     ex_data[1] = pat(2*m, 2);
            @(posedge clk);
            model[2*m + 1] = pat(2*m + 1, 2);
            if (m != 0) model[2*m] = pat(2*m, 2);
        end
        quiet_cycle();
        read_all("R2 exec sweep");

        // R4/R5: same-parity pairs on both ports
        @(negedge clk);
        ld_we = '1;
        ld_addr_a[0] = 7'd10; ld_data_a[0] = pat(10, 9);
        ld_addr_b[0] = 7'd12; ld_data_b[0] = pat(12, 9);
        ld_addr_a[1] = 7'd7;  ld_data_a[1] = pat(7, 9);
        ld_addr_b[1] = 7'd9;  ld_data_b[1] = pat(9, 9);
        rd_addr[0] = 7'd10; rd_addr[1] = 7'd12; rd_addr[2] = 7'd7; rd_addr[3] = 7'd9;
        #1;
        chk("R4 rejected pair not bypassed", rd_data[0], model[10]);
        chk("R4 rejected pair not bypassed", rd_data[2], model[7]);
        @(posedge clk); #1;
        chk("R5 error pulse both ports", ld_pair_err, 2'b11);
        quiet_cycle();
        chk("R4 reg10 unchanged", rd_data[0], model[10]);
        chk("R4 reg12 unchanged", rd_data[1], model[12]);
        chk("R4 reg7 unchanged", rd_data[2], model[7]);
        chk("R4 reg9 unchanged", rd_data[3], model[9]);
        @(posedge clk); #1;
        chk("R5 error lasts one cycle", ld_pair_err, 0);

        // R5: only the offending port flags
        @(negedge clk);
        ld_we = 2'b11;
        ld_addr_a[0] = 7'd30; ld_data_a[0] = pat(30, 4);
        ld_addr_b[0] = 7'd31; ld_data_b[0] = pat(31, 4);
        ld_addr_a[1] = 7'd40; ld_data_a[1] = pat(40, 4);
        ld_addr_b[1] = 7'd42; ld_data_b[1] = pat(42, 4);
        @(posedge clk); #1;
        model[30] = pat(30, 4); model[31] = pat(31, 4);
        chk("R5 only port 1 flags", ld_pair_err, 2'b10);
        quiet_cycle();
        rd_addr[0] = 7'd30; rd_addr[1] = 7'd31; rd_addr[2] = 7'd40; rd_addr[3] = 7'd42; #1;
        chk("R3 good pair stored", rd_data[0], model[30]);
        chk("R3 good pair stored", rd_data[1], model[31]);
        chk("R4 bad pair dropped", rd_data[2], model[40]);
        chk("R4 bad pair dropped", rd_data[3], model[42]);

        // R6/R7: ex0 beats ex1 and loads
        @(negedge clk);
        ex_we = 2'b11;
        ex_addr[0] = 7'd20; ex_data[0] = pat(20, 5);
        ex_addr[1] = 7'd20; ex_data[1] = pat(20, 6);
        ld_we = 2'b01;
        ld_addr_a[0] = 7'd20; ld_data_a[0] = pat(20, 7);
        ld_addr_b[0] = 7'd23; ld_data_b[0] = pat(23, 7);
        rd_addr[0] = 7'd20; rd_addr[1] = 7'd23; #1;
        chk("R7 bypass ex0 winner", rd_data[0], pat(20, 5));
        chk("R7 bypass load half", rd_data[1], pat(23, 7));
        @(posedge clk);
        model[20] = pat(20, 5); model[23] = pat(23, 7);
        quiet_cycle();
        chk("R6 ex0 wins stored", rd_data[0], model[20]);
        chk("R3 other half stored", rd_data[1], model[23]);

        // R6/R7: ex1 beats load
        @(negedge clk);
        ex_we = 2'b10; ex_addr[1] = 7'd21; ex_data[1] = pat(21, 8);
        ld_we = 2'b01;
        ld_addr_a[0] = 7'd21; ld_data_a[0] = pat(21, 9);
        ld_addr_b[0] = 7'd24; ld_data_b[0] = pat(24, 9);
        rd_addr[0] = 7'd21; #1;
        chk("R7 bypass ex1 winner", rd_data[0], pat(21, 8));
        @(posedge clk); model[21] = pat(21, 8); model[24] = pat(24, 9);
        quiet_cycle();
        chk("R6 ex1 over load stored", rd_data[0], model[21]);

        // R6/R7: load port 0 beats load port 1
        @(negedge clk);
        ld_we = 2'b11;
        ld_addr_a[0] = 7'd22; ld_data_a[0] = pat(22, 10);
        ld_addr_b[0] = 7'd25; ld_data_b[0] = pat(25, 10);
        ld_addr_a[1] = 7'd27; ld_data_a[1] = pat(27, 11);
        ld_addr_b[1] = 7'd22; ld_data_b[1] = pat(22, 11);
        rd_addr[0] = 7'd22; rd_addr[1] = 7'd27; #1;
        chk("R7 bypass load0 winner", rd_data[0], pat(22, 10));
        chk("R7 bypass load1 other half", rd_data[1], pat(27, 11));
        @(posedge clk);
        model[22] = pat(22, 10); model[25] = pat(25, 10); model[27] = pat(27, 11);
        quiet_cycle();
        chk("R6 load0 over load1 stored", rd_data[0], model[22]);
        chk("R6 load1 other half stored", rd_data[1], model[27]);

        // R8: writes to register 0 from every kind of port
        @(negedge clk);
        ex_we = 2'b11; ex_addr[0] = 7'd0; ex_data[0] = pat(0, 12);
        ex_addr[1] = 7'd0; ex_data[1] = pat(0, 13);
        ld_we = 2'b01;
        ld_addr_a[0] = 7'd0; ld_data_a[0] = pat(0, 14);
        ld_addr_b[0] = 7'd1; ld_data_b[0] = pat(1, 14);
        rd_addr[0] = 7'd0; rd_addr[1] = 7'd1; #1;
        chk("R8 reg0 bypass zero", rd_data[0], 0);
        chk("R7 bypass beside reg0", rd_data[1], pat(1, 14));
        @(posedge clk); model[1] = pat(1, 14);
        quiet_cycle();
        chk("R8 reg0 stays zero", rd_data[0], 0);
        chk("R3 partner of reg0 stored", rd_data[1], model[1]);

        // R7/R9: all eight ports bypass distinct in-flight writes
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            ex_we = 2'b11;
            ex_addr[0] = RF_AW'(64 + 8*s);     ex_data[0] = pat(64 + 8*s, 20);
            ex_addr[1] = RF_AW'(64 + 8*s + 1); ex_data[1] = pat(64 + 8*s + 1, 20);
            ld_we = 2'b11;
            ld_addr_a[0] = RF_AW'(64 + 8*s + 2); ld_data_a[0] = pat(64 + 8*s + 2, 20);
            ld_addr_b[0] = RF_AW'(64 + 8*s + 3); ld_data_b[0] = pat(64 + 8*s + 3, 20);
            ld_addr_a[1] = RF_AW'(64 + 8*s + 5); ld_data_a[1] = pat(64 + 8*s + 5, 20);
            ld_addr_b[1] = RF_AW'(64 + 8*s + 4); ld_data_b[1] = pat(64 + 8*s + 4, 20);
            for (int p = 0; p < RF_RD_PORTS; p++) rd_addr[p] = RF_AW'(64 + 8*s + (7 - p));
            #1;
            for (int p = 0; p < RF_RD_PORTS; p++) begin
                if (7 - p < 6) chk("R7 R9 bypass per port", rd_data[p], pat(64 + 8*s + 7 - p, 20));
                else           chk("R9 unwritten per port", rd_data[p], model[64 + 8*s + 7 - p]);
            end
            @(posedge clk);
            for (int k = 0; k < 6; k++) model[64 + 8*s + k] = pat(64 + 8*s + k, 20);
        end
        quiet_cycle();
        read_all("R9 final image");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule